// File: doc/BRIEF.md
# Wormhole Deflection Port Allocator

This block is the output-port assignment stage of a router that has no input buffers and carries packets as worms. Each cycle it sees up to four incoming flits, one per mesh input, with a valid bit, head, tail, destination coordinates, age and worm id for each. It serves them from oldest to youngest and gives every valid flit an output port in that same cycle. A flit is never held back, so a flit that cannot have a port toward its destination is deflected to another one.

A head flit reserves the port it receives for its worm. The body flits that follow reuse that reservation. A head can take a port held by a different worm. The displaced worm is then cut: its next body flit finds no reservation, is promoted to a head, and competes for a port on its own. That promoted flit leaves with its head flag set. A tail flit frees the reservation of its worm.

The grants, the output-side select and head flags, the promotion and deflection flags and the reservation table are all registered. They appear one clock edge after the flits are presented.

Top module: `wdpa_alloc`

## Requirements
- R1: Flits are served in order of decreasing age; among equal ages the lower input index goes first, and an earlier flit's port is unavailable to every later one.
- R2: Ports are north=0 (destination y above this node), east=1 (x above), south=2 (y below), west=3 (x below); a matching coordinate gives no productive port on that axis. A head takes the first non-empty class of free ports: productive and unreserved, productive and reserved, unproductive and unreserved, unproductive and reserved; within a class the lowest port index wins.
- R3: A body flit whose worm id is held by a free port's reservation goes to that port and leaves with its head flag clear.
- R4: A head that takes a port reserved by another worm overwrites that reservation with its own worm id; the displaced worm's next body flit is routed as a head, with its promotion flag set and its outgoing head flag set.
- R5: A body flit whose worm holds no reservation (never made, released, or overwritten) is promoted in the same way as in R4.
- R6: After a flit whose tail flag is set passes, the port it used is unreserved; after a non-tail head or promoted flit passes, that port is reserved for its worm id.
- R7: Every valid input gets a grant and distinct inputs get distinct ports; the number of valid outputs equals the number of valid inputs, and each output names the input granted to it.
- R8: All results and the reservation table change only at the clock edge that follows the flits they come from.
- R9: While reset is held, all output valids, grants and reservations are zero.
- R10: The deflection flag of a granted input is set exactly when its granted port is not productive for its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| here_x | input | X_W | X coordinate of this router |
| here_y | input | Y_W | Y coordinate of this router |
| in_vld | input | 4 | Flit present on each input |
| in_head | input | 4 | Flit is a worm head |
| in_tail | input | 4 | Flit is the last of its worm |
| in_dst_x | input | 4 x X_W | Destination x per input |
| in_dst_y | input | 4 x Y_W | Destination y per input |
| in_age | input | 4 x AGE_W | Age per input, larger is older |
| in_wid | input | 4 x WID_W | Worm id per input |
| out_vld | output | 4 | Output port carries a flit |
| out_src | output | 4 x 2 | Input index routed to each output |
| out_head | output | 4 | Outgoing head flag per output |
| gnt_vld | output | 4 | Input received a grant |
| gnt_port | output | 4 x 2 | Port granted to each input |
| gnt_promo | output | 4 | Body flit was promoted to head |
| gnt_defl | output | 4 | Granted port is not productive |
| alloc_vld | output | 4 | Port is reserved |
| alloc_wid | output | 4 x WID_W | Worm id holding each port |

## Verification
Every result of this block, including the reservation table, is due at the first rising edge after the flits are driven. The flits are applied at a falling edge. The bench advances its reference model at that moment and compares all outputs at the next falling edge, which is half a period after the edge that registers them. One directed step also samples the outputs before that edge to confirm that they still hold the previous values. The reservation seen by the model for each flit is the one left by the older flits of the same cycle, so same-cycle truncations and their effect on body flits a cycle later fall due at the correct edge.

// File: rtl/wdpa_pkg.sv
package wdpa_pkg;

    localparam int NP = 4;
    localparam int PW = 2;

    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_E = 2'd1,
        DIR_S = 2'd2,
        DIR_W = 2'd3
    } dir_e;

    // lowest set bit of a port mask, one-hot
    function automatic logic [NP-1:0] lowest_oh(input logic [NP-1:0] m);
        lowest_oh = m & (~m + NP'(1));
    endfunction

    // one-hot to index
    function automatic logic [PW-1:0] oh2idx(input logic [NP-1:0] oh);
        logic [PW-1:0] idx;
        idx = '0;
        for (int o = 0; o < NP; o++) begin
            if (oh[o]) idx = idx | PW'(o);
        end
        return idx;
    endfunction

endpackage

// File: rtl/wdpa_route.sv
module wdpa_route
    import wdpa_pkg::*;
#(
    parameter int X_W = 3,
    parameter int Y_W = 3
) (
    input  logic [X_W-1:0] here_x,
    input  logic [Y_W-1:0] here_y,
    input  logic [X_W-1:0] dst_x,
    input  logic [Y_W-1:0] dst_y,
    output logic [NP-1:0]  prod
);

    always_comb begin
        prod        = '0;
        prod[DIR_N] = dst_y > here_y;
        prod[DIR_E] = dst_x > here_x;
        prod[DIR_S] = dst_y < here_y;
        prod[DIR_W] = dst_x < here_x;
    end

endmodule

// File: rtl/wdpa_rank.sv
module wdpa_rank
    import wdpa_pkg::*;
#(
    parameter int AGE_W = 8
) (
    input  logic [NP-1:0]            vld,
    input  logic [NP-1:0][AGE_W-1:0] age,
    output logic [NP-1:0][NP-1:0]    slot_sel
);

    logic [NP-1:0][PW-1:0] rank;

    for (genvar i = 0; i < NP; i++) begin : g_rank
        always_comb begin
            rank[i] = '0;
            for (int j = 0; j < NP; j++) begin
                if (j != i && vld[j] &&
                    ((age[j] > age[i]) || (age[j] == age[i] && j < i))) begin
                    rank[i] = rank[i] + PW'(1);
                end
            end
        end
    end

    for (genvar r = 0; r < NP; r++) begin : g_slot
        for (genvar i = 0; i < NP; i++) begin : g_in
            assign slot_sel[r][i] = vld[i] && (rank[i] == PW'(r));
        end
    end

endmodule

// File: rtl/wdpa_slot.sv
module wdpa_slot
    import wdpa_pkg::*;
#(
    parameter int WID_W = 4
) (
    input  logic [NP-1:0]            sel_oh,
    input  logic [NP-1:0]            in_head,
    input  logic [NP-1:0]            in_tail,
    input  logic [NP-1:0][WID_W-1:0] in_wid,
    input  logic [NP-1:0][NP-1:0]    in_prod,
    input  logic [NP-1:0]            taken_i,
    input  logic [NP-1:0]            avld_i,
    input  logic [NP-1:0][WID_W-1:0] awid_i,
    output logic [NP-1:0]            taken_o,
    output logic [NP-1:0]            avld_o,
    output logic [NP-1:0][WID_W-1:0] awid_o,
    output logic [NP-1:0]            port_oh,
    output logic                     promo,
    output logic                     head_out,
    output logic                     defl
);

    logic                 f_vld;
    logic                 f_head;
    logic                 f_tail;
    logic [WID_W-1:0]     f_wid;
    logic [NP-1:0]        f_prod;
    logic [NP-1:0]        follow;
    logic [NP-1:0]        free;
    logic [3:0][NP-1:0]   lvl;
    logic [NP-1:0]        pick;
    logic                 as_head;

    // select the flit of this rank
    always_comb begin
        f_vld  = |sel_oh;
        f_head = 1'b0;
        f_tail = 1'b0;
        f_wid  = '0;
        f_prod = '0;
        for (int i = 0; i < NP; i++) begin
            if (sel_oh[i]) begin
                f_head = in_head[i];
                f_tail = in_tail[i];
                f_wid  = in_wid[i];
                f_prod = in_prod[i];
            end
        end
    end

    // port choice
    always_comb begin
        free = ~taken_i;
        for (int o = 0; o < NP; o++) begin
            follow[o] = avld_i[o] && (awid_i[o] == f_wid) && free[o];
        end
        as_head = f_head || !(|follow);

        lvl[0] =  f_prod & free & ~avld_i;
        lvl[1] =  f_prod & free &  avld_i;
        lvl[2] = ~f_prod & free & ~avld_i;
        lvl[3] = ~f_prod & free &  avld_i;
        pick = '0;
        for (int l = 3; l >= 0; l--) begin
            if (|lvl[l]) pick = lowest_oh(lvl[l]);
        end

        if (!f_vld)       port_oh = '0;
        else if (as_head) port_oh = pick;
        else              port_oh = lowest_oh(follow);

        promo    = f_vld && !f_head && as_head;
        head_out = f_vld && as_head;
        defl     = f_vld && !(|(port_oh & f_prod));
    end

    // reservation chain update
    always_comb begin
        taken_o = taken_i | port_oh;
        avld_o  = avld_i;
        awid_o  = awid_i;
        for (int o = 0; o < NP; o++) begin
            if (port_oh[o]) begin
                avld_o[o] = !f_tail;
                awid_o[o] = f_wid;
            end
        end
    end

endmodule

// File: rtl/wdpa_alloc.sv
module wdpa_alloc
    import wdpa_pkg::*;
#(
    parameter int X_W   = 3,
    parameter int Y_W   = 3,
    parameter int AGE_W = 8,
    parameter int WID_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [X_W-1:0]           here_x,
    input  logic [Y_W-1:0]           here_y,
    input  logic [NP-1:0]            in_vld,
    input  logic [NP-1:0]            in_head,
    input  logic [NP-1:0]            in_tail,
    input  logic [NP-1:0][X_W-1:0]   in_dst_x,
    input  logic [NP-1:0][Y_W-1:0]   in_dst_y,
    input  logic [NP-1:0][AGE_W-1:0] in_age,
    input  logic [NP-1:0][WID_W-1:0] in_wid,
    output logic [NP-1:0]            out_vld,
    output logic [NP-1:0][PW-1:0]    out_src,
    output logic [NP-1:0]            out_head,
    output logic [NP-1:0]            gnt_vld,
    output logic [NP-1:0][PW-1:0]    gnt_port,
    output logic [NP-1:0]            gnt_promo,
    output logic [NP-1:0]            gnt_defl,
    output logic [NP-1:0]            alloc_vld,
    output logic [NP-1:0][WID_W-1:0] alloc_wid
);

    typedef struct packed {
        logic [NP-1:0]            ovld;
        logic [NP-1:0][PW-1:0]    osrc;
        logic [NP-1:0]            ohead;
        logic [NP-1:0]            gv;
        logic [NP-1:0][PW-1:0]    gport;
        logic [NP-1:0]            promo;
        logic [NP-1:0]            defl;
        logic [NP-1:0]            avld;
        logic [NP-1:0][WID_W-1:0] awid;
    } st_t;

    st_t st_d;
    st_t st_q;

    logic [NP-1:0][NP-1:0]            prod;
    logic [NP-1:0][NP-1:0]            slot_sel;
    logic [NP:0][NP-1:0]              tk_c;
    logic [NP:0][NP-1:0]              av_c;
    logic [NP:0][NP-1:0][WID_W-1:0]   aw_c;
    logic [NP-1:0][NP-1:0]            port_oh;
    logic [NP-1:0]                    s_promo;
    logic [NP-1:0]                    s_head;
    logic [NP-1:0]                    s_defl;

    for (genvar i = 0; i < NP; i++) begin : g_route
        wdpa_route #(.X_W(X_W), .Y_W(Y_W)) u_route (
            .here_x (here_x),
            .here_y (here_y),
            .dst_x  (in_dst_x[i]),
            .dst_y  (in_dst_y[i]),
            .prod   (prod[i])
        );
    end

    wdpa_rank #(.AGE_W(AGE_W)) u_rank (
        .vld      (in_vld),
        .age      (in_age),
        .slot_sel (slot_sel)
    );

    assign tk_c[0] = '0;
    assign av_c[0] = st_q.avld;
    assign aw_c[0] = st_q.awid;

    for (genvar r = 0; r < NP; r++) begin : g_slot
        wdpa_slot #(.WID_W(WID_W)) u_slot (
            .sel_oh   (slot_sel[r]),
            .in_head  (in_head),
            .in_tail  (in_tail),
            .in_wid   (in_wid),
            .in_prod  (prod),
            .taken_i  (tk_c[r]),
            .avld_i   (av_c[r]),
            .awid_i   (aw_c[r]),
            .taken_o  (tk_c[r+1]),
            .avld_o   (av_c[r+1]),
            .awid_o   (aw_c[r+1]),
            .port_oh  (port_oh[r]),
            .promo    (s_promo[r]),
            .head_out (s_head[r]),
            .defl     (s_defl[r])
        );
    end

    always_comb begin
        st_d      = '0;
        st_d.avld = av_c[NP];
        st_d.awid = aw_c[NP];
        for (int r = 0; r < NP; r++) begin
            for (int i = 0; i < NP; i++) begin
                if (slot_sel[r][i]) begin
                    st_d.gv[i]    = 1'b1;
                    st_d.gport[i] = oh2idx(port_oh[r]);
                    st_d.promo[i] = s_promo[r];
                    st_d.defl[i]  = s_defl[r];
                end
            end
            for (int o = 0; o < NP; o++) begin
                if (port_oh[r][o]) begin
                    st_d.ovld[o]  = 1'b1;
                    st_d.osrc[o]  = oh2idx(slot_sel[r]);
                    st_d.ohead[o] = s_head[r];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld   = st_q.ovld;
    assign out_src   = st_q.osrc;
    assign out_head  = st_q.ohead;
    assign gnt_vld   = st_q.gv;
    assign gnt_port  = st_q.gport;
    assign gnt_promo = st_q.promo;
    assign gnt_defl  = st_q.defl;
    assign alloc_vld = st_q.avld;
    assign alloc_wid = st_q.awid;

endmodule

// File: rtl/wdpa_chk.sv
module wdpa_chk
    import wdpa_pkg::*;
#(
    parameter int WID_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NP-1:0]            in_vld,
    input logic [NP-1:0]            in_head,
    input logic [NP-1:0]            in_tail,
    input logic [NP-1:0][WID_W-1:0] in_wid,
    input logic [NP-1:0]            out_vld,
    input logic [NP-1:0][PW-1:0]    out_src,
    input logic [NP-1:0]            out_head,
    input logic [NP-1:0]            gnt_vld,
    input logic [NP-1:0][PW-1:0]    gnt_port,
    input logic [NP-1:0]            gnt_promo,
    input logic [NP-1:0]            alloc_vld,
    input logic [NP-1:0][WID_W-1:0] alloc_wid
);

    // flits and table as seen at the previous edge
    logic [NP-1:0]            p_vld;
    logic [NP-1:0]            p_head;
    logic [NP-1:0]            p_tail;
    logic [NP-1:0][WID_W-1:0] p_wid;
    logic [NP-1:0]            p_avld;
    logic [NP-1:0][WID_W-1:0] p_awid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_vld  <= '0;
            p_head <= '0;
            p_tail <= '0;
            p_wid  <= '0;
            p_avld <= '0;
            p_awid <= '0;
        end else begin
            p_vld  <= in_vld;
            p_head <= in_head;
            p_tail <= in_tail;
            p_wid  <= in_wid;
            p_avld <= alloc_vld;
            p_awid <= alloc_wid;
        end
    end

    AST_OUT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_vld) == $countones(p_vld)); // R7

    for (genvar o = 0; o < NP; o++) begin : g_out
        AST_OUT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[o] |-> gnt_vld[out_src[o]] && gnt_port[out_src[o]] == PW'(o)); // R7
    end

    for (genvar i = 0; i < NP; i++) begin : g_in
        AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
            !p_vld[i] |-> !gnt_vld[i]); // R7

        AST_BODY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_vld[i] && !p_head[i] && !gnt_promo[i]
            |-> p_avld[gnt_port[i]] && p_awid[gnt_port[i]] == p_wid[i]); // R3

        AST_PROMO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_vld[i] && gnt_promo[i]
            |-> out_head[gnt_port[i]] && out_src[gnt_port[i]] == PW'(i)); // R4

        AST_PROMO_BODY: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_promo[i] |-> gnt_vld[i] && !p_head[i]); // R5

        AST_TAIL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_vld[i] && p_tail[i] |-> !alloc_vld[gnt_port[i]]); // R6

        AST_HEAD_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_vld[i] && (p_head[i] || gnt_promo[i]) && !p_tail[i]
            |-> alloc_vld[gnt_port[i]] && alloc_wid[gnt_port[i]] == p_wid[i]); // R4
    end

endmodule

bind wdpa_alloc wdpa_chk #(.WID_W(WID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_head   (in_head),
    .in_tail   (in_tail),
    .in_wid    (in_wid),
    .out_vld   (out_vld),
    .out_src   (out_src),
    .out_head  (out_head),
    .gnt_vld   (gnt_vld),
    .gnt_port  (gnt_port),
    .gnt_promo (gnt_promo),
    .alloc_vld (alloc_vld),
    .alloc_wid (alloc_wid)
);

// File: tb/tb_wdpa_alloc.sv
module tb_wdpa_alloc;
    import wdpa_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int X_W   = 3;
    localparam int Y_W   = 3;
    localparam int AGE_W = 8;
    localparam int WID_W = 4;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [X_W-1:0]           here_x = 3'd3;
    logic [Y_W-1:0]           here_y = 3'd3;
    logic [NP-1:0]            in_vld = '0;
    logic [NP-1:0]            in_head = '0;
    logic [NP-1:0]            in_tail = '0;
    logic [NP-1:0][X_W-1:0]   in_dst_x = '0;
    logic [NP-1:0][Y_W-1:0]   in_dst_y = '0;
    logic [NP-1:0][AGE_W-1:0] in_age = '0;
    logic [NP-1:0][WID_W-1:0] in_wid = '0;
    logic [NP-1:0]            out_vld;
    logic [NP-1:0][PW-1:0]    out_src;
    logic [NP-1:0]            out_head;
    logic [NP-1:0]            gnt_vld;
    logic [NP-1:0][PW-1:0]    gnt_port;
    logic [NP-1:0]            gnt_promo;
    logic [NP-1:0]            gnt_defl;
    logic [NP-1:0]            alloc_vld;
    logic [NP-1:0][WID_W-1:0] alloc_wid;

    wdpa_alloc #(.X_W(X_W), .Y_W(Y_W), .AGE_W(AGE_W), .WID_W(WID_W)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference reservation table and expected results
    logic [NP-1:0]            m_avld = '0;
    logic [NP-1:0][WID_W-1:0] m_awid = '0;
    logic [NP-1:0]            e_ovld, e_ohead, e_gv, e_promo, e_defl;
    int                       e_osrc [NP];
    int                       e_gport[NP];

    task automatic fail(string tag, string what, int act, int exp);
        n_bad++;
        $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    endtask

    task automatic cmp(string tag, string what, int act, int exp);
        if (act != exp) fail(tag, what, act, exp);
    endtask

    // reference: serve oldest first, four preference classes for heads
    task automatic model_step();
        logic [NP-1:0]            done  = '0;
        logic [NP-1:0]            taken = '0;
        logic [NP-1:0]            nav   = m_avld;
        logic [NP-1:0][WID_W-1:0] naw   = m_awid;
        e_ovld = '0; e_ohead = '0; e_gv = '0; e_promo = '0; e_defl = '0;
        for (int k = 0; k < NP; k++) begin
            int b;
            b = -1;
            for (int i = 0; i < NP; i++)
                if (in_vld[i] && !done[i] && (b < 0 || in_age[i] > in_age[b])) b = i;
            if (b >= 0) begin
                logic [NP-1:0] pm;
                int  port;
                bit  hd;
                done[b] = 1'b1;
                pm[0] = in_dst_y[b] > here_y;
                pm[1] = in_dst_x[b] > here_x;
                pm[2] = in_dst_y[b] < here_y;
                pm[3] = in_dst_x[b] < here_x;
                port = -1;
                if (!in_head[b])
                    for (int o = 0; o < NP; o++)
                        if (port < 0 && nav[o] && naw[o] == in_wid[b] && !taken[o]) port = o;
                hd = in_head[b] || port < 0;
                if (hd)
                    for (int l = 0; l < 4; l++)
                        for (int o = 0; o < NP; o++)
                            if (port < 0 && !taken[o] && (pm[o] == (l < 2)) && (nav[o] == (l % 2 == 1)))
                                port = o;
                taken[port]  = 1'b1;
                nav[port]    = !in_tail[b];
                naw[port]    = in_wid[b];
                e_gv[b]      = 1'b1;
                e_gport[b]   = port;
                e_promo[b]   = !in_head[b] && hd;
                e_defl[b]    = !pm[port];
                e_ovld[port] = 1'b1;
                e_osrc[port] = b;
                e_ohead[port] = hd;
            end
        end
        m_avld = nav;
        m_awid = naw;
    endtask

    task automatic check_all();
        n_vec++;
        cmp("R7", "out_vld", int'(out_vld), int'(e_ovld));
        cmp("R7", "gnt_vld", int'(gnt_vld), int'(e_gv));
        for (int o = 0; o < NP; o++) begin
            if (e_ovld[o]) begin
                cmp("R7", $sformatf("out_src[%0d]", o), int'(out_src[o]), e_osrc[o]);
                cmp("R4", $sformatf("out_head[%0d]", o), int'(out_head[o]), int'(e_ohead[o]));
            end
            cmp("R6", $sformatf("alloc_vld[%0d]", o), int'(alloc_vld[o]), int'(m_avld[o]));
            if (m_avld[o])
                cmp("R6", $sformatf("alloc_wid[%0d]", o), int'(alloc_wid[o]), int'(m_awid[o]));
        end
        for (int i = 0; i < NP; i++) begin
            if (e_gv[i]) begin
                cmp(e_promo[i] ? "R4" : (e_ohead[e_gport[i]] ? "R2" : "R3"),
                    $sformatf("gnt_port[%0d]", i), int'(gnt_port[i]), e_gport[i]);
                cmp("R5", $sformatf("gnt_promo[%0d]", i), int'(gnt_promo[i]), int'(e_promo[i]));
                cmp("R10", $sformatf("gnt_defl[%0d]", i), int'(gnt_defl[i]), int'(e_defl[i]));
            end
        end
    endtask

    task automatic clear_in();
        in_vld = '0; in_head = '0; in_tail = '0;
    endtask

    task automatic set_flit(int p, bit h, bit t, int dx, int dy, int age, int wid);
        in_vld[p]   = 1'b1;
        in_head[p]  = h;
        in_tail[p]  = t;
        in_dst_x[p] = X_W'(dx);
        in_dst_y[p] = Y_W'(dy);
        in_age[p]   = AGE_W'(age);
        in_wid[p]   = WID_W'(wid);
    endtask

    // inputs are set at a falling edge; results are due after the next rising edge
    task automatic run_cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        // R9: reset state
        n_vec++;
        cmp("R9", "out_vld in reset", int'(out_vld), 0);
        cmp("R9", "gnt_vld in reset", int'(gnt_vld), 0);
        cmp("R9", "alloc_vld in reset", int'(alloc_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: lone head heading east takes free productive east port
        clear_in();
        set_flit(0, 1, 0, 5, 3, 10, 1);
        #1;
        n_vec++;
        cmp("R8", "out_vld before edge", int'(out_vld), 0);
        run_cycle();
        cmp("R2", "head east port", int'(gnt_port[0]), 1);
        cmp("R6", "east reserved", int'(alloc_vld[1]), 1);

        // R3: body follows reservation even toward west destination
        clear_in();
        set_flit(0, 0, 0, 0, 3, 10, 1);
        run_cycle();
        cmp("R3", "body follows", int'(gnt_port[0]), 1);
        cmp("R3", "body head flag", int'(out_head[1]), 0);

        // R1: two heads for reserved east; older wins, younger deflected to north
        clear_in();
        set_flit(1, 1, 0, 6, 3, 50, 2);
        set_flit(2, 1, 0, 6, 3, 40, 3);
        run_cycle();
        cmp("R1", "older head gets east", int'(gnt_port[1]), 1);
        cmp("R1", "younger head deflected north", int'(gnt_port[2]), 0);
        cmp("R10", "younger deflect flag", int'(gnt_defl[2]), 1);
        cmp("R4", "east overwritten", int'(alloc_wid[1]), 2);

        // R4: truncated worm's body is promoted; tail frees its port (R6)
        clear_in();
        set_flit(0, 0, 1, 3, 5, 10, 1);
        run_cycle();
        cmp("R4", "promoted flag", int'(gnt_promo[0]), 1);
        cmp("R4", "promoted north", int'(gnt_port[0]), 0);
        cmp("R4", "promoted head out", int'(out_head[0]), 1);
        cmp("R6", "single flit leaves port free", int'(alloc_vld[0]), 0);

        // R6: tail body releases east
        clear_in();
        set_flit(1, 0, 1, 6, 3, 50, 2);
        run_cycle();
        cmp("R6", "tail released east", int'(alloc_vld[1]), 0);

        // R7 and R1 tie: four equal-age heads all eastbound
        clear_in();
        for (int p = 0; p < NP; p++) set_flit(p, 1, 1, 7, 3, 7, 8 + p);
        run_cycle();
        cmp("R7", "all outputs used", int'(out_vld), 15);
        cmp("R1", "tie lowest index east", int'(gnt_port[0]), 1);

        // R5: body of an unknown worm is promoted
        clear_in();
        set_flit(3, 0, 0, 3, 0, 3, 15);
        run_cycle();
        cmp("R5", "unknown worm promoted", int'(gnt_promo[3]), 1);
        cmp("R2", "promoted head south", int'(gnt_port[3]), 2);

        // random traffic, bodies biased toward live worms
        for (int c = 0; c < 3000; c++) begin
            clear_in();
            for (int p = 0; p < NP; p++) begin
                if ($urandom_range(99) < 60) begin
                    int wid;
                    bit h;
                    h = $urandom_range(99) < 40;
                    wid = $urandom_range((1 << WID_W) - 1);
                    if (!h && $urandom_range(99) < 75) begin
                        for (int o = 0; o < NP; o++)
                            if (m_avld[o] && $urandom_range(1) == 1) wid = int'(m_awid[o]);
                    end
                    set_flit(p, h, $urandom_range(99) < 30,
                             $urandom_range(7), $urandom_range(7),
                             $urandom_range(255), wid);
                end
            end
            run_cycle();
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule